// File: doc/BRIEF.md
# Event Input Glitch Filter

This block cleans up an asynchronous event pin before a log controller sees it. It samples the pin with a slow internal sampling clock and passes it through a synchronizer. A change of level counts as recognized only after the synchronized value has held for one further sample. A recognized change then opens a fixed processing window. If the pin holds its new level until the window closes, the block emits a one-cycle strobe. It also updates an output that carries the level the event moved to, so a falling edge and a rising edge can be told apart. If the pin goes back to the accepted level before the window closes, the pending event is discarded and nothing is emitted.

Quantizing to the sampling clock, plus the window, sets a minimum event duration. With the default two synchronizer stages and an eight-cycle window, a pulse must cover ten sampling edges to be logged. Anything shorter is dropped. Changes that arrive during a window are never stored for later. They either cancel the pending event or are ignored.

Top module: `evt_glitch_filter`

## Requirements
- R1: While reset is asserted (`rst_n` low at a clock edge), and in the cycle after, `evt_stb`, `evt_busy` and `evt_level` are all 0.
- R2: A rising change of `evt_in` set up before clock edge k, and held, makes `evt_busy` go high after edge k+SYNC_STAGES+1. `evt_busy` stays high for exactly PROC_LEN cycles. `evt_stb` is high for one cycle after edge k+SYNC_STAGES+PROC_LEN+1, and `evt_level` becomes 1 at that same edge.
- R3: A falling change, held long enough, is also an event: same timing as R2, with `evt_level` becoming 0.
- R4: A pulse seen at a single sampling edge never raises `evt_busy` and never produces a strobe.
- R5: A pulse that raises `evt_busy` but ends before the window closes drops `evt_busy` with no strobe, and `evt_level` is unchanged.
- R6: With the defaults, a pulse covering PROC_LEN+2 sampling edges or more is logged, giving a strobe for its start and another for its end. A pulse covering PROC_LEN+1 edges or fewer gives no strobe.
- R7: `evt_stb` is never high for two cycles in a row and is never high together with `evt_busy`.
- R8: A short return to the previous level during a window cancels that event and is not queued. The next strobe comes only one full recognition-plus-window interval after the pin settles again.
- R9: A level that is held steady after it has been logged produces no further strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous event pin |
| evt_stb | output | 1 | One-cycle pulse when an event is accepted |
| evt_busy | output | 1 | High while a recognized event is in its processing window |
| evt_level | output | 1 | Level of the pin as of the last accepted event |

## Verification
Let the pin change before edge k. `evt_busy` is due after edge k+3, and `evt_stb` together with the new `evt_level` is due after edge k+11. A cancel shows on `evt_busy` two edges after the pin returns. The bench changes the pin at a falling clock edge and counts falling edges from that moment. It samples exactly at the falling edge where the result is due, and also at the one before, so an output that is one cycle early or late is caught. In the table-driven pulse runs, strobes are counted over a window long enough to cover the start and end events of each pulse.

// File: rtl/evt_filt_pkg.sv
// Shared types for the event glitch filter.
package evt_filt_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROC = 1'b1
    } proc_phase_t;
endpackage

// File: rtl/evt_sync.sv
// Multi-stage synchronizer for the asynchronous event pin.
// Assumes STAGES >= 2. Every stage resets to 0, the level of an idle pin.
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the pin level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/evt_edge_rec.sv
// Edge recognizer: flags a level that differs from the accepted reference
// and has held for one extra sample. Also reports a return to the reference.
// Assumes lvl_sync is already synchronous to clk.
module evt_edge_rec (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_sync,
    input  logic lvl_ref,
    output logic recog,
    output logic back_to_ref
);
    logic lvl_prev;

    // remember the previous synchronized sample
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl_sync;
    end

    // a new level is recognized once two samples in a row agree on it
    always_comb begin
        recog       = (lvl_sync != lvl_ref) && (lvl_sync == lvl_prev);
        back_to_ref = (lvl_sync == lvl_ref);
    end
endmodule

// File: rtl/evt_proc_fsm.sv
// Processing-window controller. A recognized change starts a window of
// PROC_LEN cycles. If the level holds to the end, a one-cycle strobe is
// emitted and the reference level flips. A return to the reference during
// the window cancels the event. Nothing is queued.
// Assumes PROC_LEN >= 2.
module evt_proc_fsm
    import evt_filt_pkg::*;
#(
    parameter int PROC_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recog,
    input  logic back_to_ref,
    output logic busy,
    output logic stb,
    output logic lvl_ref
);
    localparam int CNT_W = $clog2(PROC_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROC_LEN - 1);

    proc_phase_t      phase;
    logic [CNT_W-1:0] cnt;

    // window sequencing, strobe generation and reference update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            stb     <= 1'b0;
            lvl_ref <= 1'b0;
        end else begin
            stb <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (recog) phase <= PH_PROC;
                end
                PH_PROC: begin
                    if (back_to_ref) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else if (cnt == CNT_LAST) begin
                        phase   <= PH_IDLE;
                        cnt     <= '0;
                        stb     <= 1'b1;
                        lvl_ref <= ~lvl_ref;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase == PH_PROC);
endmodule

// File: rtl/evt_glitch_filter.sv
// Top level of the event glitch filter: synchronizer, edge recognizer and
// processing-window controller in a chain. Assumes clk is the slow internal
// sampling clock and that evt_in may change at any time.
module evt_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int PROC_LEN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_stb,
    output logic evt_busy,
    output logic evt_level
);
    logic lvl_sync;
    logic recog;
    logic back_to_ref;
    logic lvl_ref;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (evt_in),
        .q_sync  (lvl_sync)
    );

    evt_edge_rec u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_sync    (lvl_sync),
        .lvl_ref     (lvl_ref),
        .recog       (recog),
        .back_to_ref (back_to_ref)
    );

    evt_proc_fsm #(.PROC_LEN(PROC_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .recog       (recog),
        .back_to_ref (back_to_ref),
        .busy        (evt_busy),
        .stb         (evt_stb),
        .lvl_ref     (lvl_ref)
    );

    assign evt_level = lvl_ref;
endmodule

// File: rtl/evt_glitch_filter_chk.sv
// Property checker for the event glitch filter, bound to the top module.
// Counts consecutive busy cycles, so the window length is checked without
// a parameter-deep $past.
module evt_glitch_filter_chk #(
    parameter int PROC_LEN = 8
) (
    input logic clk,
    input logic rst_n,
    input logic evt_stb,
    input logic evt_busy,
    input logic evt_level
);
    localparam int RUN_W = $clog2(PROC_LEN + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PROC_LEN);

    logic [RUN_W-1:0] busy_run;

    // count consecutive busy cycles up to the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_run <= '0;
        else if (evt_busy) busy_run <= busy_run + 1'b1;
        else               busy_run <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!evt_stb && !evt_busy && !evt_level));

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |=> !evt_stb);

    // R7
    stb_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_stb && evt_busy));

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_busy |-> (busy_run < RUN_MAX));

    // R2
    stb_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |-> (busy_run == RUN_MAX));

    // R3
    level_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |-> (evt_level != $past(evt_level)));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_stb && $past(rst_n)) |-> $stable(evt_level));
endmodule

bind evt_glitch_filter evt_glitch_filter_chk #(.PROC_LEN(PROC_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_stb   (evt_stb),
    .evt_busy  (evt_busy),
    .evt_level (evt_level)
);

// File: tb/evt_glitch_filter_bench.sv
`timescale 1ns/1ps
module evt_glitch_filter_bench;
    localparam int S = 2;
    localparam int L = 8;
    localparam int BUSY_AT = S + 2;        // falling edges from pin change
    localparam int STB_AT  = S + L + 2;
    localparam int NVEC = 7;
    // {pulse length in sampling edges, accepted}
    localparam int VEC [NVEC][2] = '{
        '{1, 0}, '{2, 0}, '{5, 0}, '{L + 1, 0}, '{L + 2, 1}, '{L + 4, 1}, '{20, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_in = 1'b0;
    logic evt_stb, evt_busy, evt_level;
    int total = 0;
    int bad = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_glitch_filter #(.SYNC_STAGES(S), .PROC_LEN(L)) u_evt_glitch_filter (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .evt_stb(evt_stb), .evt_busy(evt_busy), .evt_level(evt_level)
    );

    always @(negedge clk) if (evt_stb) stb_seen++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int c0;
        wait_neg(4);
        chk("R1 stb in reset", evt_stb, 0);
        chk("R1 busy in reset", evt_busy, 0);
        chk("R1 level in reset", evt_level, 0);
        rst_n = 1'b1;
        wait_neg(1);
        chk("R1 busy after reset", evt_busy, 0);

        // table walk over pulse lengths (R4, R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            c0 = stb_seen;
            evt_in = 1'b1;
            wait_neg(VEC[v][0]);
            evt_in = 1'b0;
            wait_neg(40);
            chk($sformatf("R6 strobes for pulse %0d", VEC[v][0]),
                stb_seen - c0, VEC[v][1] != 0 ? 2 : 0);
            chk("R5 level after pulse", evt_level, 0);
        end

        // R4: single-sample pulse never raises busy
        evt_in = 1'b1;
        wait_neg(1);
        evt_in = 1'b0;
        c0 = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (evt_busy) c0++;
        end
        chk("R4 busy cycles for 1-sample pulse", c0, 0);

        // R2: rising edge timing
        c0 = stb_seen;
        evt_in = 1'b1;
        wait_neg(BUSY_AT - 1);
        chk("R2 busy not yet", evt_busy, 0);
        wait_neg(1);
        chk("R2 busy rises", evt_busy, 1);
        wait_neg(STB_AT - BUSY_AT - 1);
        chk("R2 busy last cycle", evt_busy, 1);
        chk("R7 no early stb", evt_stb, 0);
        wait_neg(1);
        chk("R2 stb due", evt_stb, 1);
        chk("R7 busy low with stb", evt_busy, 0);
        chk("R2 level high", evt_level, 1);
        wait_neg(1);
        chk("R7 stb one cycle", evt_stb, 0);

        // R9: held level gives no more strobes
        wait_neg(50);
        chk("R9 single strobe while held", stb_seen - c0, 1);

        // R3: falling edge timing
        evt_in = 1'b0;
        wait_neg(STB_AT - 1);
        chk("R3 no early stb", evt_stb, 0);
        wait_neg(1);
        chk("R3 stb due", evt_stb, 1);
        chk("R3 level low", evt_level, 0);
        wait_neg(20);

        // R8: one-sample return during the window cancels, nothing queued
        c0 = stb_seen;
        evt_in = 1'b1;
        wait_neg(BUSY_AT + 2);
        chk("R8 busy before glitch", evt_busy, 1);
        evt_in = 1'b0;
        wait_neg(1);
        evt_in = 1'b1;
        wait_neg(S);
        chk("R8 cancelled", evt_busy, 0);
        wait_neg(STB_AT - S - 1);
        chk("R8 no early stb", evt_stb, 0);
        wait_neg(1);
        chk("R8 stb after restart", evt_stb, 1);
        wait_neg(30);
        chk("R8 exactly one strobe", stb_seen - c0, 1);

        // R1: reset during a window
        evt_in = 1'b0;
        wait_neg(BUSY_AT + 1);
        rst_n = 1'b0;
        wait_neg(1);
        chk("R1 busy cleared by reset", evt_busy, 0);
        chk("R1 level cleared by reset", evt_level, 0);
        rst_n = 1'b1;
        wait_neg(5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule